// File: doc/BRIEF.md
# Chip-Select-Gated Registered Command Buffer

This block sits on a memory module's command and address path. It samples the address and command field, the clock-enable and termination controls, and the chip selects on the rising clock edge. It drives them out one cycle later on two output banks, A and B, so that two groups of memory devices each get their own copy. Chip selects are active low. The address and command registers load only in cycles where at least one chip select is asserted. In all other cycles they hold, which keeps the wide output bus from toggling.

A static mode pin, `quad_en_n_i`, chooses how chip selects are routed.

- **Paired arrangement (pin high):** two chip-select inputs are each copied to both banks.
- **Quad arrangement (pin low):** four chip-select inputs map one-to-one onto the four chip-select outputs. In this arrangement, a group of the most significant address and command bits is driven on bank A only. Bank B carries zero in those positions.

An asynchronous active-low reset forces every output to its idle value.

Top module: `cmd_reg_buffer`

## Requirements
- R1: Inputs are captured on the rising edge of `clk`, and registered outputs reflect them one cycle later. In a valid cycle, `ca_a_o` equals the `ca_i` sampled at the previous edge.
- R2: With `quad_en_n_i` = 1 (paired), `csa_n_o` and `csb_n_o` both equal `cs_n_i[1:0]` from the previous edge. `cs_n_i[3:2]` affect neither the chip-select outputs nor the validity of a cycle.
- R3: With `quad_en_n_i` = 0 (quad), `csa_n_o` equals `cs_n_i[1:0]` and `csb_n_o` equals `cs_n_i[3:2]`, both from the previous edge.
- R4: A cycle is valid when any chip select in the active set is 0. The active set is bits [1:0] in paired mode and bits [3:0] in quad mode. After a cycle that is not valid, `ca_a_o` and `ca_b_o` keep their previous values.
- R5: In paired mode, a valid cycle loads all CA_W bits of `ca_i` into both `ca_b_o` and `ca_a_o`.
- R6: In quad mode, a valid cycle loads bits [CA_W-1 : CA_W-GRP_W] of `ca_i` into `ca_a_o` only, and loads zero into the same bits of `ca_b_o`. The remaining lower bits load into both banks.
- R7: `cke_o` and `odt_o` equal `cke_i` and `odt_i` from the previous edge in every cycle, whatever the chip selects are.
- R8: While `rst_n` is 0, without waiting for a clock edge, `csa_n_o` and `csb_n_o` are all ones and `ca_a_o`, `ca_b_o`, `cke_o` and `odt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| quad_en_n_i | input | 1 | Static mode pin: 1 paired chip selects, 0 quad chip selects |
| cs_n_i | input | 4 | Chip selects, active low (bits [3:2] used only in quad mode) |
| ca_i | input | CA_W (22) | Address and command field |
| cke_i | input | CTL_W (2) | Clock-enable controls |
| odt_i | input | CTL_W (2) | Termination controls |
| csa_n_o | output | 2 | Bank A chip-select outputs |
| csb_n_o | output | 2 | Bank B chip-select outputs |
| ca_a_o | output | CA_W (22) | Bank A address and command |
| ca_b_o | output | CA_W (22) | Bank B address and command |
| cke_o | output | CTL_W (2) | Registered clock-enable controls |
| odt_o | output | CTL_W (2) | Registered termination controls |

## Verification
The properties assume that `quad_en_n_i` changes only while `rst_n` is low. This is because validity and the bank B group contents are judged against the mode seen one edge earlier. The stimulus therefore sets the mode inside a reset window and then sweeps every 16-value chip-select pattern under several data words. The sweep interleaves valid and idle cycles, so holds and loads alternate. Inputs change only on falling edges, which keeps them stable around each sampling edge.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

   localparam int CS_IN_W   = 4;
   localparam int CS_BANK_W = CS_IN_W / 2;

   typedef enum logic {
      CS_PAIRED = 1'b0,
      CS_QUAD   = 1'b1
   } cs_arr_e;

   function automatic cs_arr_e decode_mode(input logic quad_en_n);
      return quad_en_n ? CS_PAIRED : CS_QUAD;
   endfunction

endpackage

// File: rtl/cmdbuf_flop.sv
module cmdbuf_flop #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (en) begin
         q <= d;
      end
   end

endmodule

// File: rtl/cmdbuf_cs_stage.sv
module cmdbuf_cs_stage
   import cmdbuf_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  cs_arr_e              mode,
   input  logic [CS_IN_W-1:0]   cs_n_i,
   output logic [CS_BANK_W-1:0] csa_n_o,
   output logic [CS_BANK_W-1:0] csb_n_o,
   output logic                 valid_o
);

   logic [CS_BANK_W-1:0] lo_sel;
   logic [CS_BANK_W-1:0] hi_sel;
   logic [CS_BANK_W-1:0] b_next;

   assign lo_sel = cs_n_i[CS_BANK_W-1:0];
   assign hi_sel = cs_n_i[CS_IN_W-1:CS_BANK_W];

   always_comb begin
      if (mode == CS_QUAD) begin
         b_next  = hi_sel;
         valid_o = ~&cs_n_i;
      end else begin
         b_next  = lo_sel;
         valid_o = ~&lo_sel;
      end
   end

   cmdbuf_flop #(.W(CS_BANK_W), .RST_VAL({CS_BANK_W{1'b1}})) u_cs_a (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(lo_sel), .q(csa_n_o)
   );

   cmdbuf_flop #(.W(CS_BANK_W), .RST_VAL({CS_BANK_W{1'b1}})) u_cs_b (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(b_next), .q(csb_n_o)
   );

endmodule

// File: rtl/cmdbuf_ca_stage.sv
module cmdbuf_ca_stage
   import cmdbuf_pkg::*;
#(
   parameter int CA_W  = 22,
   parameter int GRP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  cs_arr_e         mode,
   input  logic [CA_W-1:0] ca_i,
   output logic [CA_W-1:0] ca_a_o,
   output logic [CA_W-1:0] ca_b_o
);

   localparam int SPLIT = CA_W - GRP_W;

   logic [GRP_W-1:0] grp_b_next;

   assign grp_b_next = (mode == CS_QUAD) ? '0 : ca_i[CA_W-1:SPLIT];

   cmdbuf_flop #(.W(CA_W)) u_bank_a (
      .clk(clk), .rst_n(rst_n), .en(load), .d(ca_i), .q(ca_a_o)
   );

   if (SPLIT > 0) begin : g_shared_b
      cmdbuf_flop #(.W(SPLIT)) u_bank_b_lo (
         .clk(clk), .rst_n(rst_n), .en(load),
         .d(ca_i[SPLIT-1:0]), .q(ca_b_o[SPLIT-1:0])
      );
   end

   cmdbuf_flop #(.W(GRP_W)) u_bank_b_grp (
      .clk(clk), .rst_n(rst_n), .en(load),
      .d(grp_b_next), .q(ca_b_o[CA_W-1:SPLIT])
   );

endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer
   import cmdbuf_pkg::*;
#(
   parameter int CA_W  = 22,
   parameter int GRP_W = 4,
   parameter int CTL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 quad_en_n_i,
   input  logic [CS_IN_W-1:0]   cs_n_i,
   input  logic [CA_W-1:0]      ca_i,
   input  logic [CTL_W-1:0]     cke_i,
   input  logic [CTL_W-1:0]     odt_i,
   output logic [CS_BANK_W-1:0] csa_n_o,
   output logic [CS_BANK_W-1:0] csb_n_o,
   output logic [CA_W-1:0]      ca_a_o,
   output logic [CA_W-1:0]      ca_b_o,
   output logic [CTL_W-1:0]     cke_o,
   output logic [CTL_W-1:0]     odt_o
);

   if (GRP_W < 1 || GRP_W > CA_W) begin : g_bad_grp
      $error("cmd_reg_buffer: GRP_W must lie in 1..CA_W");
   end
   if (CTL_W < 1) begin : g_bad_ctl
      $error("cmd_reg_buffer: CTL_W must be at least 1");
   end

   cs_arr_e mode;
   logic    cyc_valid;

   assign mode = decode_mode(quad_en_n_i);

   cmdbuf_cs_stage u_cs (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n_i(cs_n_i),
      .csa_n_o(csa_n_o), .csb_n_o(csb_n_o), .valid_o(cyc_valid)
   );

   cmdbuf_ca_stage #(.CA_W(CA_W), .GRP_W(GRP_W)) u_ca (
      .clk(clk), .rst_n(rst_n), .load(cyc_valid), .mode(mode),
      .ca_i(ca_i), .ca_a_o(ca_a_o), .ca_b_o(ca_b_o)
   );

   cmdbuf_flop #(.W(CTL_W)) u_cke (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cke_i), .q(cke_o)
   );

   cmdbuf_flop #(.W(CTL_W)) u_odt (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(odt_i), .q(odt_o)
   );

endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
   parameter int CA_W  = 22,
   parameter int GRP_W = 4,
   parameter int CTL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             quad_en_n_i,
   input logic [3:0]       cs_n_i,
   input logic [CA_W-1:0]  ca_i,
   input logic [CTL_W-1:0] cke_i,
   input logic [CTL_W-1:0] odt_i,
   input logic [1:0]       csa_n_o,
   input logic [1:0]       csb_n_o,
   input logic [CA_W-1:0]  ca_a_o,
   input logic [CA_W-1:0]  ca_b_o,
   input logic [CTL_W-1:0] cke_o,
   input logic [CTL_W-1:0] odt_o
);

   localparam logic [CA_W-1:0] LO_MASK = {CA_W{1'b1}} >> GRP_W;
   localparam logic [CA_W-1:0] HI_MASK = ~LO_MASK;

   logic in_valid;
   logic live_q;
   logic rst_seen_q;

   assign in_valid = quad_en_n_i ? (cs_n_i[1:0] != 2'b11) : (cs_n_i != 4'hF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      rst_seen_q <= !rst_n;
   end

   // R8: idle outputs throughout reset
   always_ff @(posedge clk) begin
      if (!rst_n && rst_seen_q) begin
         assert_idle_in_reset_R8: assert (csa_n_o == 2'b11 && csb_n_o == 2'b11 &&
                                          ca_a_o == '0 && ca_b_o == '0 &&
                                          cke_o == '0 && odt_o == '0);
      end
   end

   assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(in_valid) |-> ca_a_o == $past(ca_i));

   assert_paired_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && quad_en_n_i |-> csa_n_o == $past(cs_n_i[1:0]) && csb_n_o == $past(cs_n_i[1:0]));

   assert_quad_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !quad_en_n_i |-> csa_n_o == $past(cs_n_i[1:0]) && csb_n_o == $past(cs_n_i[3:2]));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !$past(in_valid) |-> $stable(ca_a_o) && $stable(ca_b_o));

   assert_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && quad_en_n_i && $past(in_valid) |-> ca_b_o == $past(ca_i));

   assert_grp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !quad_en_n_i && $past(in_valid) |->
         (ca_b_o & HI_MASK) == '0 && ((ca_b_o ^ $past(ca_i)) & LO_MASK) == '0);

   assert_ctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> cke_o == $past(cke_i) && odt_o == $past(odt_i));

endmodule

bind cmd_reg_buffer cmdbuf_chk #(.CA_W(CA_W), .GRP_W(GRP_W), .CTL_W(CTL_W)) u_chk (.*);

// File: tb/cmd_reg_buffer_tb_top.sv
module cmd_reg_buffer_tb_top;

   localparam int CA_W  = 22;
   localparam int GRP_W = 4;
   localparam int CTL_W = 2;
   localparam logic [CA_W-1:0] LO_MASK = {CA_W{1'b1}} >> GRP_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             quad_en_n_i = 1'b1;
   logic [3:0]       cs_n_i = 4'hF;
   logic [CA_W-1:0]  ca_i = '0;
   logic [CTL_W-1:0] cke_i = '0;
   logic [CTL_W-1:0] odt_i = '0;
   logic [1:0]       csa_n_o, csb_n_o;
   logic [CA_W-1:0]  ca_a_o, ca_b_o;
   logic [CTL_W-1:0] cke_o, odt_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [CA_W-1:0]  exp_a, exp_b;
   logic [1:0]       exp_csa, exp_csb;
   logic [CTL_W-1:0] exp_cke, exp_odt;

   cmd_reg_buffer #(.CA_W(CA_W), .GRP_W(GRP_W), .CTL_W(CTL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .quad_en_n_i(quad_en_n_i), .cs_n_i(cs_n_i),
      .ca_i(ca_i), .cke_i(cke_i), .odt_i(odt_i),
      .csa_n_o(csa_n_o), .csb_n_o(csb_n_o), .ca_a_o(ca_a_o), .ca_b_o(ca_b_o),
      .cke_o(cke_o), .odt_o(odt_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_idle_exp();
      exp_a = '0; exp_b = '0; exp_csa = 2'b11; exp_csb = 2'b11;
      exp_cke = '0; exp_odt = '0;
   endtask

   task automatic chk_idle();
      chk("R8 csa", 64'(csa_n_o), 64'(2'b11));
      chk("R8 csb", 64'(csb_n_o), 64'(2'b11));
      chk("R8 ca_a", 64'(ca_a_o), 64'd0);
      chk("R8 ca_b", 64'(ca_b_o), 64'd0);
      chk("R8 cke", 64'(cke_o), 64'd0);
      chk("R8 odt", 64'(odt_o), 64'd0);
   endtask

   task automatic do_reset(input logic qn);
      @(negedge clk);
      rst_n = 1'b0;
      quad_en_n_i = qn;
      cs_n_i = 4'hF;
      @(posedge clk);
      @(posedge clk);
      #5;
      chk_idle();
      set_idle_exp();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One cycle: drive on the falling edge, model the rising edge, compare 5 ns later.
   task automatic step(input logic [3:0] cs, input logic [CA_W-1:0] ca,
                       input logic [CTL_W-1:0] ke, input logic [CTL_W-1:0] ot);
      logic quad;
      logic valid;
      @(negedge clk);
      cs_n_i = cs; ca_i = ca; cke_i = ke; odt_i = ot;
      quad  = !quad_en_n_i;
      valid = quad ? (cs != 4'hF) : (cs[1:0] != 2'b11);
      @(posedge clk);
      if (valid) begin
         exp_a = ca;
         exp_b = quad ? (ca & LO_MASK) : ca;
      end
      exp_csa = cs[1:0];
      exp_csb = quad ? cs[3:2] : cs[1:0];
      exp_cke = ke;
      exp_odt = ot;
      #5;
      chk(valid ? "R1 ca_a load" : "R4 ca_a hold", 64'(ca_a_o), 64'(exp_a));
      chk(quad ? (valid ? "R6 ca_b" : "R4 ca_b hold") : (valid ? "R5 ca_b" : "R4 ca_b hold"),
          64'(ca_b_o), 64'(exp_b));
      chk(quad ? "R3 csa" : "R2 csa", 64'(csa_n_o), 64'(exp_csa));
      chk(quad ? "R3 csb" : "R2 csb", 64'(csb_n_o), 64'(exp_csb));
      chk("R7 cke", 64'(cke_o), 64'(exp_cke));
      chk("R7 odt", 64'(odt_o), 64'(exp_odt));
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         do_reset(m == 0 ? 1'b1 : 1'b0);
         for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 16; c++) begin
               step(4'(c ^ (k * 5)),
                    CA_W'(32'h2D3A5 * 32'(k * 16 + c + 1) + 32'(m) * 32'h11),
                    CTL_W'(c), CTL_W'(c + k));
            end
         end
         // R8: reset asserted between edges takes effect without a clock
         @(posedge clk);
         #5;
         rst_n = 1'b0;
         #2;
         chk_idle();
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule